// File: doc/BRIEF.md
# Oversampling Serial Byte Receiver

This block receives asynchronous serial bytes on a single input line. A tick arrives from an external rate generator at either sixteen or eight times the bit rate, chosen by a mode input that may change between frames. The receiver watches the synchronized line on each tick. A falling edge starts a frame, and the sample counter is aligned to that edge. The receiver then takes three samples around the middle of every bit and keeps the majority value. A start bit that votes high is treated as noise and dropped.

Each frame has one low start bit, eight data bits sent least significant bit first, and one stop bit. A finished byte goes into a two-entry buffer together with a flag that marks a low stop bit. The consumer reads the oldest byte while the data-available flag is high and pops it with a one-cycle read strobe. Clearing the enable stops reception at once, throws away any partial frame, and empties the buffer.

Top module: `serial_rx_recover`

## Requirements
- R1: With `half_rate` low a bit lasts 16 ticks; with it high a bit lasts 8 ticks.
- R2: A frame starts only when a tick sample of the synchronized line is low and the previous idle sample was high. A line that stays low after a frame starts nothing.
- R3: Each bit takes the majority of its samples at positions 8, 9 and 10 (16x) or 4, 5 and 6 (8x), counting the first low start sample as position 1. A single wrong sample does not change the byte.
- R4: A start bit whose majority vote is high is dropped, no byte is produced, and the receiver waits for the next falling edge.
- R5: Data bits arrive least significant bit first. `rd_data` shows the oldest unread byte and holds steady until it is read.
- R6: `rd_ferr` is 1 for a byte whose stop bit voted low and 0 otherwise. It is stored with that byte.
- R7: `data_avail` is high exactly while the buffer holds a byte. A `rd_stb` pulse while it is high removes one byte.
- R8: The buffer holds two bytes. A byte that completes while the buffer is full and no read occurs is dropped and sets `overrun`. `overrun` stays set until the receiver is disabled.
- R9: If a read and a byte completion fall in the same cycle on a full buffer, the new byte is kept and `overrun` stays low.
- R10: When `rx_en` is low, the next clock empties the buffer, clears `overrun`, and discards any frame in progress. Ticks and line activity are ignored while it stays low.
- R11: A change of `half_rate` between frames applies to the next frame.
- R12: After reset the buffer is empty and `overrun` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| os_tick | input | 1 | One-cycle oversampling tick |
| rx_en | input | 1 | Receiver enable; low aborts and flushes |
| half_rate | input | 1 | 1: 8 ticks per bit, 0: 16 ticks per bit |
| rxd | input | 1 | Asynchronous serial line, idle high |
| rd_stb | input | 1 | Pops the oldest byte |
| rd_data | output | 8 | Oldest unread byte |
| rd_ferr | output | 1 | Frame-error flag of the oldest byte |
| data_avail | output | 1 | Buffer holds at least one byte |
| overrun | output | 1 | A byte was dropped on a full buffer |

## Verification
The case that needs care is a read strobe that lands in the same cycle as a byte completion while both buffer entries are full. In that cycle a pop and a push both act on the buffer. The bench fills the buffer, starts a third frame, and watches its reference model for the cycle in which the finished byte will be written. It raises the read strobe in exactly that cycle. It then expects the second and third bytes in order, with no overrun. The model is compared every clock, so a design that drops the byte or flags overrun there is caught.

// File: rtl/srx_pkg.sv
// Shared types for the serial byte receiver.
// Assumes a fixed data width with one start and one stop bit per frame.
package srx_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic {
        RX_IDLE  = 1'b0,
        RX_FRAME = 1'b1
    } srx_state_t;

    typedef struct packed {
        logic              ferr;
        logic [BYTE_W-1:0] data;
    } srx_word_t;
endpackage

// File: rtl/srx_sync.sv
// Multi-flop synchronizer for the asynchronous serial line.
// Assumes the line idles high, so every stage resets to one.
module srx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    // shift the line through the synchronizer stages
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/srx_frame.sv
// Frame engine: finds start edges, counts ticks within each bit, votes
// three mid-bit samples and assembles a byte, LSB first.
// Assumes rxs is already synchronized and os_tick is one clock wide.
module srx_frame
    import srx_pkg::*;
#(
    parameter int MAX_OSR = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      rx_en,
    input  logic      os_tick,
    input  logic      half_rate,
    input  logic      rxs,
    output logic      push,
    output srx_word_t word
);
    localparam int CW       = $clog2(MAX_OSR) + 1;
    localparam int STOP_IDX = BYTE_W + 1;
    localparam int BW       = $clog2(STOP_IDX + 1);

    srx_state_t        st;
    logic [CW-1:0]     osr, lo, hi, cnt, cnt_n;
    logic [BW-1:0]     bitn;
    logic [1:0]        ones;
    logic [BYTE_W-1:0] sh;
    logic              prev;
    logic              wrap, in_win, decide, vote;

    assign osr    = half_rate ? CW'(MAX_OSR / 2) : CW'(MAX_OSR);
    assign lo     = osr >> 1;
    assign hi     = lo + CW'(2);
    assign wrap   = cnt >= osr;
    assign cnt_n  = cnt + CW'(1);
    assign in_win = (cnt_n >= lo) && (cnt_n <= hi);
    assign decide = cnt_n == hi;
    assign vote   = ({1'b0, ones} + {2'b00, rxs}) >= 3'd2;

    // sequence the frame: edge search, tick count, voting and byte hand-off
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= RX_IDLE;
            cnt  <= '0;
            bitn <= '0;
            ones <= '0;
            sh   <= '0;
            prev <= 1'b1;
            push <= 1'b0;
            word <= '0;
        end else if (!rx_en) begin
            st   <= RX_IDLE;
            prev <= 1'b1;
            push <= 1'b0;
        end else begin
            push <= 1'b0;
            if (os_tick) begin
                if (st == RX_IDLE) begin
                    prev <= rxs;
                    if (prev && !rxs) begin
                        st   <= RX_FRAME;
                        cnt  <= CW'(1);
                        bitn <= '0;
                        ones <= '0;
                    end
                end else if (wrap) begin
                    cnt  <= CW'(1);
                    ones <= '0;
                    if (bitn >= BW'(STOP_IDX)) begin
                        st   <= RX_IDLE;
                        prev <= rxs;
                    end else begin
                        bitn <= bitn + BW'(1);
                    end
                end else begin
                    cnt <= cnt_n;
                    if (in_win) ones <= ones + {1'b0, rxs};
                    if (decide) begin
                        if (bitn == '0) begin
                            if (vote) begin
                                st   <= RX_IDLE;
                                prev <= rxs;
                            end
                        end else if (bitn == BW'(STOP_IDX)) begin
                            push      <= 1'b1;
                            word.data <= sh;
                            word.ferr <= !vote;
                            st        <= RX_IDLE;
                            prev      <= rxs;
                        end else begin
                            sh <= {vote, sh[BYTE_W-1:1]};
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/srx_buf.sv
// Small receive buffer with overrun detection.
// Assumes push is one clock wide; a pop in the same cycle frees room.
module srx_buf
    import srx_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      rx_en,
    input  logic      push,
    input  srx_word_t din,
    input  logic      rd_stb,
    output srx_word_t head,
    output logic      avail,
    output logic      ovr
);
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNTW = $clog2(DEPTH + 1);

    srx_word_t       mem [DEPTH];
    logic [PW-1:0]   wr_ptr, rd_ptr;
    logic [CNTW-1:0] count, cnt_nx;
    logic            pop, wr_ok;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    assign pop   = rd_stb && (count != '0);
    assign wr_ok = push && ((count < CNTW'(DEPTH)) || pop);
    assign avail = count != '0;
    assign head  = mem[rd_ptr];

    // next occupancy from the accepted write and the pop
    always_comb begin
        cnt_nx = count;
        if (wr_ok && !pop)      cnt_nx = count + CNTW'(1);
        else if (!wr_ok && pop) cnt_nx = count - CNTW'(1);
    end

    // pointers, occupancy and sticky overrun; disable flushes all of it
    always_ff @(posedge clk) begin
        if (!rst_n || !rx_en) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            ovr    <= 1'b0;
        end else begin
            count <= cnt_nx;
            if (pop)           rd_ptr <= bump(rd_ptr);
            if (wr_ok)         wr_ptr <= bump(wr_ptr);
            if (push && !wr_ok) ovr   <= 1'b1;
        end
    end

    // store accepted bytes
    always_ff @(posedge clk) begin
        if (rx_en && wr_ok) mem[wr_ptr] <= din;
    end
endmodule

// File: rtl/serial_rx_recover.sv
// Top of the oversampling serial receiver: synchronizer, frame engine
// and receive buffer. Assumes os_tick comes from an external rate
// generator at 16x (or 8x with half_rate) the bit rate.
module serial_rx_recover
    import srx_pkg::*;
#(
    parameter int MAX_OSR     = 16,
    parameter int SYNC_STAGES = 2,
    parameter int BUF_DEPTH   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              os_tick,
    input  logic              rx_en,
    input  logic              half_rate,
    input  logic              rxd,
    input  logic              rd_stb,
    output logic [BYTE_W-1:0] rd_data,
    output logic              rd_ferr,
    output logic              data_avail,
    output logic              overrun
);
    logic      rxs, push;
    srx_word_t word, head;

    srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rxd),
        .dout (rxs)
    );

    srx_frame #(.MAX_OSR(MAX_OSR)) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_en    (rx_en),
        .os_tick  (os_tick),
        .half_rate(half_rate),
        .rxs      (rxs),
        .push     (push),
        .word     (word)
    );

    srx_buf #(.DEPTH(BUF_DEPTH)) u_buf (
        .clk   (clk),
        .rst_n (rst_n),
        .rx_en (rx_en),
        .push  (push),
        .din   (word),
        .rd_stb(rd_stb),
        .head  (head),
        .avail (data_avail),
        .ovr   (overrun)
    );

    assign rd_data = head.data;
    assign rd_ferr = head.ferr;
endmodule

// File: rtl/srx_checker.sv
// Port-level protocol checks for serial_rx_recover, bound to every instance.
module srx_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_en,
    input logic       rd_stb,
    input logic       data_avail,
    input logic       overrun,
    input logic [7:0] rd_data
);
    AST_FLUSH_ON_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !data_avail); // R10
    AST_OVR_ON_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !overrun); // R10
    AST_AVAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && data_avail && !rd_stb) |=> data_avail); // R7
    AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && data_avail && !rd_stb) |=> $stable(rd_data)); // R5
    AST_OVR_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $past(data_avail)); // R8
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && rx_en) |=> overrun); // R8
endmodule

bind serial_rx_recover srx_checker u_chk (.*);

// File: tb/sim_serial_rx_recover.sv
`timescale 1ns/1ps
module sim_serial_rx_recover;
    logic clk = 0, rst_n = 0, os_tick = 0, rx_en = 0, half_rate = 0, rxd = 1, rd_stb = 0;
    logic [7:0] rd_data;
    logic rd_ferr, data_avail, overrun;
    int n_chk = 0, n_bad = 0, tdiv = 0;
    bit done = 0;

    always #2 clk = ~clk;

    serial_rx_recover u0 (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_en(rx_en),
        .half_rate(half_rate), .rxd(rxd), .rd_stb(rd_stb),
        .rd_data(rd_data), .rd_ferr(rd_ferr), .data_avail(data_avail),
        .overrun(overrun)
    );

    // tick every fourth clock
    always @(negedge clk) begin
        tdiv    <= (tdiv == 3) ? 0 : tdiv + 1;
        os_tick <= (tdiv == 3);
    end

    // behavioural reference
    bit m_s1 = 1, m_s2 = 1, m_busy = 0, m_prev = 1, m_push = 0, m_pf = 0, m_ovr = 0;
    logic [7:0] m_sh = 0, m_pd = 0;
    int m_pos = 0, m_idx = 0, m_hits = 0;
    logic [8:0] mq[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = 1; m_s2 = 1; m_busy = 0; m_prev = 1; m_push = 0; m_ovr = 0;
            mq.delete();
        end else begin
            if (!rx_en) begin
                mq.delete(); m_ovr = 0;
            end else begin
                bit pop, room;
                pop  = rd_stb && mq.size() > 0;
                room = mq.size() < 2 || pop;
                if (pop) void'(mq.pop_front());
                if (m_push) begin
                    if (room) mq.push_back({m_pf, m_pd});
                    else m_ovr = 1;
                end
            end
            m_push = 0;
            if (!rx_en) begin
                m_busy = 0; m_prev = 1;
            end else if (os_tick) begin
                int osr;
                bit smp, v;
                osr = half_rate ? 8 : 16;
                smp = m_s2;
                if (!m_busy) begin
                    if (!smp && m_prev) begin m_busy = 1; m_pos = 1; m_idx = 0; m_hits = 0; end
                    m_prev = smp;
                end else if (m_pos >= osr) begin
                    m_pos = 1; m_hits = 0;
                    if (m_idx >= 9) begin m_busy = 0; m_prev = smp; end
                    else m_idx++;
                end else begin
                    m_pos++;
                    if (m_pos >= osr / 2 && m_pos <= osr / 2 + 2) m_hits += smp;
                    if (m_pos == osr / 2 + 2) begin
                        v = m_hits >= 2;
                        if (m_idx == 0) begin
                            if (v) begin m_busy = 0; m_prev = smp; end
                        end else if (m_idx == 9) begin
                            m_push = 1; m_pd = m_sh; m_pf = !v; m_busy = 0; m_prev = smp;
                        end else m_sh = {v, m_sh[7:1]};
                    end
                end
            end
            m_s2 = m_s1; m_s1 = rxd;
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // compare against the reference on every clock
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(data_avail == (mq.size() > 0), "R7", "data_avail", data_avail, mq.size() > 0);
            chk(overrun == m_ovr, "R8", "overrun", overrun, m_ovr);
            if (mq.size() > 0) begin
                chk(rd_data == mq[0][7:0], "R5", "rd_data", rd_data, mq[0][7:0]);
                chk(rd_ferr == mq[0][8], "R6", "rd_ferr", rd_ferr, mq[0][8]);
            end
        end
    end

    task automatic wait_ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            while (!os_tick) @(posedge clk);
        end
        @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] b, input bit stopv, input int flip_bit);
        int osr;
        osr = half_rate ? 8 : 16;
        for (int i = 0; i < 10; i++) begin
            bit v;
            v = (i == 0) ? 1'b0 : (i == 9) ? stopv : b[i-1];
            rxd = v;
            if (i == flip_bit) begin
                wait_ticks(osr / 2); rxd = ~v; wait_ticks(1); rxd = v; wait_ticks(osr - osr / 2 - 1);
            end else wait_ticks(osr);
        end
    endtask

    task automatic pop_one();
        @(negedge clk) rd_stb = 1;
        @(negedge clk) rd_stb = 0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(data_avail == 0, "R12", "avail after reset", data_avail, 0);
        chk(overrun == 0, "R12", "overrun after reset", overrun, 0);
        rx_en = 1; wait_ticks(20);

        send_frame(8'hA5, 1, -1); wait_ticks(4);          // R1 R5 16x
        chk(data_avail == 1, "R5", "avail", data_avail, 1);
        chk(rd_data == 8'hA5, "R1", "16x byte", rd_data, 8'hA5);
        chk(rd_ferr == 0, "R6", "good stop", rd_ferr, 0);
        pop_one();
        chk(data_avail == 0, "R7", "drained", data_avail, 0);

        half_rate = 1; wait_ticks(10);                    // R11 8x
        send_frame(8'h3C, 1, -1); wait_ticks(4);
        chk(rd_data == 8'h3C, "R11", "8x byte", rd_data, 8'h3C);
        pop_one();

        rxd = 0; wait_ticks(2); rxd = 1; wait_ticks(30);  // R4 glitch
        chk(data_avail == 0, "R4", "glitch dropped", data_avail, 0);

        half_rate = 0; wait_ticks(10);
        send_frame(8'h81, 0, -1); wait_ticks(40);         // R6 R2
        chk(rd_data == 8'h81, "R6", "byte with bad stop", rd_data, 8'h81);
        chk(rd_ferr == 1, "R6", "frame error", rd_ferr, 1);
        pop_one();
        chk(data_avail == 0, "R2", "low line no frame", data_avail, 0);
        rxd = 1; wait_ticks(20);
        chk(data_avail == 0, "R2", "rise no frame", data_avail, 0);

        send_frame(8'h5A, 1, 4); wait_ticks(4);           // R3
        chk(rd_data == 8'h5A, "R3", "vote rejects flip", rd_data, 8'h5A);
        pop_one();

        send_frame(8'h11, 1, -1); send_frame(8'h22, 1, -1); send_frame(8'h33, 1, -1);
        wait_ticks(4);                                    // R8
        chk(overrun == 1, "R8", "overrun set", overrun, 1);
        chk(rd_data == 8'h11, "R8", "first kept", rd_data, 8'h11);
        pop_one();
        chk(rd_data == 8'h22, "R8", "second kept", rd_data, 8'h22);
        pop_one();
        chk(data_avail == 0, "R8", "third dropped", data_avail, 0);
        chk(overrun == 1, "R8", "overrun sticky", overrun, 1);

        rx_en = 0; @(negedge clk);                        // R10
        chk(overrun == 0, "R10", "overrun cleared", overrun, 0);
        rx_en = 1; wait_ticks(10);

        send_frame(8'h44, 1, -1); send_frame(8'h55, 1, -1); // R9
        fork
            send_frame(8'h66, 1, -1);
            begin
                @(negedge clk);
                while (!m_push) @(negedge clk);
                rd_stb = 1;
                @(negedge clk) rd_stb = 0;
            end
        join
        wait_ticks(4);
        chk(rd_data == 8'h55, "R9", "head after same-cycle read", rd_data, 8'h55);
        chk(overrun == 0, "R9", "no overrun", overrun, 0);
        pop_one();
        chk(rd_data == 8'h66, "R9", "new byte kept", rd_data, 8'h66);
        pop_one();

        send_frame(8'h77, 1, -1);                         // R10 abort mid-frame
        fork
            send_frame(8'h99, 1, -1);
            begin
                wait_ticks(50); rx_en = 0;
                @(negedge clk);
                chk(data_avail == 0, "R10", "flushed", data_avail, 0);
            end
        join
        rxd = 1; rx_en = 1; wait_ticks(30);
        chk(data_avail == 0, "R10", "partial discarded", data_avail, 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        done = 1;
        n_chk++; n_bad++;
        $display("FAIL R7 watchdog actual=hang expected=done");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule